// File: doc/BRIEF.md
# Programmable Three-Channel PWM Sequencer

This block drives three PWM outputs. Each channel runs a short program of 16-bit words held in its own local memory, and that program sets the channel's 8-bit level. A program can set the level at once, ramp it one count at a time at a chosen pace, or jump back to its first word so that it runs forever. All three channels share one 8-bit counter. The counter advances on each pulse of an external timebase strobe, which in normal use is a 32768 Hz tick. Each channel's output is the result of comparing its level with that counter.

Software uses a write-only byte bus. Address 0x30 holds one enable bit per channel. Addresses 0x38, 0x39 and 0x3A load programs into channels 0, 1 and 2. Each word goes in as two bytes, high byte first. A channel takes program bytes only while it is disabled. Writing a zero bit for a channel at 0x30 clears that channel's program, so the next load starts again at word 0.

Top module: `pwmSeqTop`

## Requirements
- R1: The shared 8-bit counter resets to 0x00. It advances by exactly one on every clock where `tick` is high and wraps from 0xFF to 0x00.
- R2: `pwmOut[c]` is high when all three hold: channel c is enabled, its level is non-zero, and its level is greater than or equal to the counter.
- R3: Bit c of a write to address 0x30 sets the enable of channel c. While disabled, a channel's output is low. Writing 0 to bit c also discards that channel's loaded program. Setting bit c starts execution at word 0, and the level keeps the value it already had.
- R4: A write to address 0x38+c loads channel c: the first byte is the high half of a word and the second byte completes the word. Writes to a channel's load port are ignored while that channel is enabled.
- R5: Each channel stores up to 64 words, and further words are dropped. When execution reaches a word that was never loaded, or passes word 63, the channel halts and keeps its level.
- R6: A word with bit 14 set and bits 13:8 zero sets the level to the bitwise inverse of bits 7:0. An operand of 0xFF therefore keeps the output off, and 0x00 keeps it on.
- R7: Any other word is a ramp if it is non-zero and does not have both bit 15 and bit 13 set. Bits 6:0 give the step count and bit 7 the direction: 1 raises the level, 0 lowers it. Each step moves the level by one and stops at 0x00 or 0xFF rather than wrapping. A count of 0 moves straight to the next word. After the last step, the next word is fetched.
- R8: The number of ticks per ramp step is the step time in bits 13:8 multiplied by the divider. The divider is `PRE_HI` when bit 14 is set and `PRE_LO` when it is clear. A step time of 0 counts as 1.
- R9: A word with bits 15 and 13 both set jumps to word 0. The word 0x0000 does nothing and moves to the next word.
- R10: A synchronous active-high `rst` clears all enables, load pointers, levels and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe, one clock wide |
| wrEn | input | 1 | Byte write strobe |
| wrAddr | input | 8 | Byte write address |
| wrData | input | 8 | Byte write data |
| pwmOut | output | 3 | Channel outputs |

## Verification
Every tick, the bench compares each output with a level model that it computes from the program fields. A wrong compare edge, a ramp that wraps instead of stopping, or a step period off by one all show up as an output that differs at some counter value. Directed cases cover:
- operands 0xFF and 0x00, where a design that drops the zero-level rule or inverts the operand the wrong way gives a stray pulse or a gap;
- a zero-count ramp, which a careless decoder would stall on;
- a full 64-word program followed by an extra word, which an unguarded pointer would execute;
- loads while enabled, which must not change the running program;
- a disable followed by a re-enable, which must not replay a ramp.

// File: rtl/pwmSeqPkg.sv
package pwmSeqPkg;
  localparam int NCH = 3;
  localparam int MEM_DEPTH = 64;
  localparam int PTR_W = $clog2(MEM_DEPTH) + 1;
  localparam logic [7:0] CTRL_ADDR = 8'h30;
  localparam logic [7:0] LOAD_BASE = 8'h38;

  // strobes from bus control to datapath
  typedef struct packed {
    logic [NCH-1:0] enable;
    logic [NCH-1:0] enRise;
    logic [NCH-1:0] rewind;
    logic [NCH-1:0] byteWr;
    logic [7:0]     byteData;
  } seqStrobe_t;

  typedef enum logic [1:0] {OP_NOP, OP_SET, OP_RAMP, OP_JUMP} opKind_t;

  function automatic opKind_t decodeOp(input logic [15:0] w);
    if (w[15] && w[13]) return OP_JUMP;
    if (w == 16'h0000) return OP_NOP;
    if (w[14] && (w[13:8] == 6'd0)) return OP_SET;
    return OP_RAMP;
  endfunction
endpackage

// File: rtl/pwmSeqCtrl.sv
module pwmSeqCtrl
  import pwmSeqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  output seqStrobe_t stb
);
  logic [NCH-1:0] enReg;
  logic [NCH-1:0] enNext;
  logic           ctrlHit;

  assign ctrlHit = wrEn && (wrAddr == CTRL_ADDR);
  assign enNext  = ctrlHit ? wrData[NCH-1:0] : enReg;

  always_ff @(posedge clk) begin
    if (rst) enReg <= '0;
    else     enReg <= enNext;
  end

  always_comb begin
    stb.enable   = enReg;
    stb.enRise   = enNext & ~enReg;
    stb.rewind   = ctrlHit ? ~wrData[NCH-1:0] : '0;
    stb.byteData = wrData;
    for (int c = 0; c < NCH; c++)
      stb.byteWr[c] = wrEn && !enReg[c] && (wrAddr == LOAD_BASE + 8'(c));
  end
endmodule

// File: rtl/pwmSeqDatapath.sv
module pwmSeqDatapath
  import pwmSeqPkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  seqStrobe_t     stb,
  output logic [7:0]     pwmCnt,
  output logic [NCH-1:0] pwmOut
);
  localparam int DIV_MAX = (PRE_HI > PRE_LO) ? PRE_HI : PRE_LO;
  localparam int PER_W = $clog2(DIV_MAX * 63 + 1);
  localparam int IDX_W = PTR_W - 1;

  always_ff @(posedge clk) begin
    if (rst)       pwmCnt <= 8'h00;
    else if (tick) pwmCnt <= pwmCnt + 8'd1;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : gChan
    logic [15:0]      mem [MEM_DEPTH];
    logic [PTR_W-1:0] wrPtr, pc;
    logic             hiPend, ramping, rampUp;
    logic [7:0]       hiByte, level, stepped;
    logic [6:0]       stepsLeft;
    logic [PER_W-1:0] period, rampCnt, periodNew;
    logic [15:0]      word;
    logic             halted, memFull;
    opKind_t          op;

    assign word    = mem[pc[IDX_W-1:0]];
    assign halted  = pc >= wrPtr;
    assign memFull = wrPtr >= PTR_W'(MEM_DEPTH);
    assign op      = decodeOp(word);

    always_comb begin
      int stepT, divSel;
      stepT     = (word[13:8] == 6'd0) ? 1 : int'(word[13:8]);
      divSel    = word[14] ? PRE_HI : PRE_LO;
      periodNew = PER_W'(stepT * divSel);
      if (rampUp) stepped = (level == 8'hFF) ? level : level + 8'd1;
      else        stepped = (level == 8'h00) ? level : level - 8'd1;
    end

    always_ff @(posedge clk) begin
      if (stb.byteWr[ch] && hiPend && !memFull)
        mem[wrPtr[IDX_W-1:0]] <= {hiByte, stb.byteData};
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        wrPtr <= '0; hiPend <= 1'b0; hiByte <= 8'h00;
        pc <= '0; ramping <= 1'b0; rampUp <= 1'b0; level <= 8'h00;
        stepsLeft <= '0; period <= '0; rampCnt <= '0;
      end else begin
        if (stb.rewind[ch]) begin
          wrPtr <= '0; hiPend <= 1'b0;
        end else if (stb.byteWr[ch]) begin
          if (!hiPend) begin
            hiByte <= stb.byteData; hiPend <= 1'b1;
          end else begin
            hiPend <= 1'b0;
            if (!memFull) wrPtr <= wrPtr + PTR_W'(1);
          end
        end

        if (stb.enRise[ch]) begin
          pc <= '0; ramping <= 1'b0; rampCnt <= '0;
        end else if (stb.enable[ch]) begin
          if (ramping) begin
            if (tick) begin
              if (rampCnt == period - PER_W'(1)) begin
                rampCnt   <= '0;
                level     <= stepped;
                stepsLeft <= stepsLeft - 7'd1;
                if (stepsLeft == 7'd1) begin
                  ramping <= 1'b0; pc <= pc + PTR_W'(1);
                end
              end else begin
                rampCnt <= rampCnt + PER_W'(1);
              end
            end
          end else if (!halted) begin
            unique case (op)
              OP_NOP:  pc <= pc + PTR_W'(1);
              OP_SET:  begin level <= ~word[7:0]; pc <= pc + PTR_W'(1); end
              OP_JUMP: pc <= '0;
              OP_RAMP: begin
                if (word[6:0] == 7'd0) pc <= pc + PTR_W'(1);
                else begin
                  ramping <= 1'b1; stepsLeft <= word[6:0]; rampUp <= word[7];
                  rampCnt <= '0;   period <= periodNew;
                end
              end
              default: pc <= pc;
            endcase
          end
        end
      end
    end

    assign pwmOut[ch] = stb.enable[ch] && (level != 8'h00) && (level >= pwmCnt);
  end
endmodule

// File: rtl/pwmSeqTop.sv
module pwmSeqTop
  import pwmSeqPkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  output logic [2:0] pwmOut
);
  seqStrobe_t     stb;
  logic [7:0]     pwmCnt;
  logic [NCH-1:0] chanEn;

  assign chanEn = stb.enable;

  pwmSeqCtrl uCtrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .stb(stb)
  );

  pwmSeqDatapath #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) uDp (
    .clk(clk), .rst(rst), .tick(tick), .stb(stb), .pwmCnt(pwmCnt), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/pwmSeqChk.sv
module pwmSeqChk
  import pwmSeqPkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           wrEn,
  input logic [7:0]     wrAddr,
  input logic [7:0]     wrData,
  input logic [NCH-1:0] pwmOut,
  input logic [NCH-1:0] chanEn,
  input logic [7:0]     pwmCnt
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> pwmCnt == $past(pwmCnt) + 8'd1); // R1
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pwmCnt)); // R1
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == CTRL_ADDR) |=> chanEn == $past(wrData[NCH-1:0])); // R3
  AST_EN_KEEP: assert property (@(posedge clk) disable iff (rst)
    !(wrEn && wrAddr == CTRL_ADDR) |=> $stable(chanEn)); // R3
  AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
    (pwmOut & ~chanEn) == '0); // R3
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pwmOut == '0 && pwmCnt == 8'h00)); // R10
endmodule

bind pwmSeqTop pwmSeqChk uChk (
  .clk(clk), .rst(rst), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .pwmOut(pwmOut), .chanEn(chanEn), .pwmCnt(pwmCnt)
);

// File: tb/sim_pwmSeqTop.sv
module sim_pwmSeqTop;
  localparam int CLK_PERIOD = 10;
  localparam int P_LO = 2;
  localparam int P_HI = 5;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wrEn = 1'b0;
  logic [7:0] wrAddr = 8'h00, wrData = 8'h00;
  logic [2:0] pwmOut;

  int errors = 0, checks = 0;
  logic [7:0] benchCnt = 8'h00;
  int mCh = 0, mEn = 0, mStart = 0, mUp = 0, mN = 0, mPer = 1, mLoop = 0, mK = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmSeqTop #(.PRE_LO(P_LO), .PRE_HI(P_HI)) u0 (
    .clk(clk), .rst(rst), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .pwmOut(pwmOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (tick %0d)", tag, act, exp, mK);
    end
  endtask

  function automatic int expLevel(int start, int up, int n, int per, int loop, int k);
    int steps, total, ph, lv;
    if (n == 0) return start;
    total = n * per;
    if (loop != 0 && k > 0) begin
      ph = k % total;
      steps = (ph == 0) ? n : ph / per;
    end else begin
      steps = (k / per > n) ? n : k / per;
    end
    lv = (up != 0) ? start + steps : start - steps;
    if (lv > 255) lv = 255;
    if (lv < 0) lv = 0;
    return lv;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busWr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic loadWord(input int ch, input logic [15:0] w);
    busWr(8'h38 + 8'(ch), w[15:8]);
    busWr(8'h38 + 8'(ch), w[7:0]);
  endtask

  task automatic runTicks(input int num, input string tag);
    for (int i = 0; i < num; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      benchCnt = benchCnt + 8'd1;
      mK++;
      begin
        int lv; bit e; logic [2:0] others;
        lv = expLevel(mStart, mUp, mN, mPer, mLoop, mK);
        e = (mEn != 0) && (lv != 0) && (lv >= int'(benchCnt));
        chk(pwmOut[mCh] == e, {tag, " R1 R2 compare"}, int'(pwmOut[mCh]), int'(e));
        others = pwmOut & ~(3'b001 << mCh);
        chk(others == 3'b000, "R3 idle channels low", int'(others), 0);
      end
      idle(3);
    end
  endtask

  task automatic runTrial(input int ch, input int op, input int up, input int n,
                          input int st, input int ps, input int loop, input int num,
                          input string tag);
    busWr(8'h30, 8'h00);
    loadWord(ch, 16'h4000 | 16'(op));
    if (n > 0) loadWord(ch, {1'b0, 1'(ps), 6'(st), 1'(up), 7'(n)});
    if (loop != 0) loadWord(ch, 16'hA000);
    busWr(8'h30, 8'(1 << ch));
    idle(6);
    mCh = ch; mEn = 1; mStart = 255 - op; mUp = up; mN = n;
    mPer = ((st == 0) ? 1 : st) * ((ps != 0) ? P_HI : P_LO);
    mLoop = loop; mK = 0;
    runTicks(num, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    chk(pwmOut == 3'b000, "R10 outputs after reset", int'(pwmOut), 0);

    // R10 R5: levels cleared by reset, empty programs halt at once
    busWr(8'h30, 8'h07);
    idle(6);
    mCh = 0; mEn = 1; mStart = 0; mN = 0; mK = 0;
    runTicks(20, "R10 R5 empty program");

    // R6: set-level extremes and a mid value
    runTrial(0, 8'hFF, 0, 0, 0, 0, 0, 260, "R6 operand FF off");
    runTrial(1, 8'h00, 0, 0, 0, 0, 0, 260, "R6 operand 00 on");
    runTrial(2, 8'h40, 0, 0, 0, 0, 0, 260, "R6 operand 40");

    // R4: load while enabled is ignored
    loadWord(2, 16'h4000);
    runTicks(40, "R4 load while enabled");

    // R7: saturation at both ends
    runTrial(0, 8'h02, 1, 10, 1, 0, 0, 60, "R7 ramp clamps high");
    runTrial(1, 8'hFD, 0, 10, 1, 0, 0, 60, "R7 ramp clamps low");

    // R3: disable clears program, re-enable keeps level
    runTrial(0, 8'h80, 1, 10, 1, 0, 0, 40, "R7 R8 ramp up");
    begin
      int held;
      held = expLevel(mStart, mUp, mN, mPer, mLoop, mK);
      busWr(8'h30, 8'h00);
      mEn = 0;
      runTicks(20, "R3 disabled low");
      busWr(8'h30, 8'h01);
      idle(6);
      mEn = 1; mStart = held; mN = 0; mK = 0;
      runTicks(40, "R3 re-enable holds level");
    end

    // R5 R9: 63 no-ops, a set at word 63, one dropped extra word
    busWr(8'h30, 8'h00);
    for (int i = 0; i < 63; i++) loadWord(1, 16'h0000);
    loadWord(1, 16'h4030);
    loadWord(1, 16'h4000);
    busWr(8'h30, 8'h02);
    idle(80);
    mCh = 1; mEn = 1; mStart = 8'hCF; mN = 0; mK = 0;
    runTicks(260, "R5 R9 full memory");

    // R7: zero-count ramp falls through
    busWr(8'h30, 8'h00);
    loadWord(0, 16'h40FF);
    loadWord(0, 16'h0180);
    loadWord(0, 16'h4020);
    busWr(8'h30, 8'h01);
    idle(6);
    mCh = 0; mEn = 1; mStart = 8'hDF; mN = 0; mK = 0;
    runTicks(260, "R7 zero count ramp");

    // R8 R9: slow divider with looping program
    runTrial(1, 8'h80, 1, 4, 2, 1, 1, 120, "R8 R9 slow divider loop");

    // random programs
    for (int t = 0; t < 16; t++) begin
      int ch, op, up, n, st, ps, loop, per;
      ch = $urandom % 3; op = $urandom % 256; up = $urandom % 2;
      n = 1 + $urandom % 12; ps = $urandom % 2; loop = $urandom % 2;
      st = (ps != 0) ? 1 + $urandom % 3 : $urandom % 4;
      per = ((st == 0) ? 1 : st) * ((ps != 0) ? P_HI : P_LO);
      runTrial(ch, op, up, n, st, ps, loop, n * per + 20, "R7 R8 R9 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule